// File: doc/BRIEF.md
# Variable-Size Set Row Allocator for a Prefix Cache

This block decides which row of a ternary prefix cache receives a new entry. The cache rows are split into 32 sets indexed by suffix length, meaning the number of don't-care low bits. Each set owns one contiguous row range, given by a configured base row and size. Sizes differ from set to set and may be zero. Because the lower set numbers sit at the lower row numbers, a row-ordered priority encoder in the cache still returns the longest prefix first.

An insert request carries a key, a suffix length and a port. The block scans the row range of that set and picks a row. An empty row wins over any occupied row. When the set is full, the victim is chosen by the replacement policy set by a parameter: least recently used (the default), first-in-first-out, or pseudo-random. The block then issues a single-cycle row write. This write carries the key with its suffix bits cleared, the care mask, and the port. Lookup hits reported by the cache refresh the recency of the row that was hit. Loading a set range flushes all occupancy.

Top module: `prefix_row_alloc`

## Requirements
- R1: After reset `ins_ready` is 1, `wr_en`, `ins_err` and `cfg_err` are 0, and every set has size 0.
- R2: A configuration write with base plus size greater than the row count raises `cfg_err` in the cycle after the write and is not stored. An insert to that set then still reports `ins_err`.
- R3: A configuration write with nonzero size whose range overlaps the range of another set of nonzero size raises `cfg_err` in the cycle after the write and is not stored.
- R4: An insert to a set of size zero is accepted and pulses `ins_err` in the cycle after acceptance. It produces no row write.
- R5: When the target set holds an empty row, the lowest-numbered empty row of the set is written.
- R6: With the least-recently-used policy, touching a row (a row write, or a hit whose row lies inside the given set) makes that row occupied with age 0. Every other occupied row of the same set with a smaller age than the touched row ages by one; if the touched row was empty, every other occupied row of the set ages by one. A full set evicts its oldest row.
- R7: `wr_en` is high for exactly one cycle, size+1 cycles after the insert is accepted, where size is the size of the target set. `ins_ready` stays low from acceptance until that write.
- R8: During a write, `wr_row` lies inside the range of the target set and `wr_port` equals the request port. `wr_care` is all ones shifted left by the suffix length, and `wr_key` is the request key ANDed with `wr_care`.
- R9: An accepted configuration write empties every row, so the next insert to any set takes the base row of that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one set range (acted on while idle) |
| cfg_set | input | 5 | Set being configured |
| cfg_base | input | 6 | First row of the set |
| cfg_size | input | 7 | Number of rows in the set |
| cfg_err | output | 1 | Configuration rejected (range or overlap) |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Block can accept an insert |
| ins_set | input | 5 | Suffix length of the new entry |
| ins_key | input | 32 | Prefix key of the new entry |
| ins_port | input | 4 | Output port of the new entry |
| ins_err | output | 1 | Insert aimed at a zero-size set |
| hit_valid | input | 1 | Lookup hit report |
| hit_set | input | 5 | Set of the hit row |
| hit_row | input | 6 | Row that hit |
| wr_en | output | 1 | Row write strobe |
| wr_row | output | 6 | Row to write |
| wr_key | output | 32 | Key with suffix bits cleared |
| wr_care | output | 32 | Care mask, 1 = compared bit |
| wr_port | output | 4 | Port stored with the row |

## Verification
Inserts are run into sets of size one, two, three, five and six. This separates the free-row path from the eviction path, and also exposes off-by-one errors at range ends. Directed hits on an old row, made before a full set is refilled, show that recency governs the victim rather than write order. A long mixed stream of random inserts and hits is compared against a reference age model. Misconfigured ranges and empty sets are checked for their error pulses and for the absence of writes.

// File: rtl/prefix_alloc_pkg.sv
package prefix_alloc_pkg;
  typedef enum logic [1:0] {POL_LRU, POL_FIFO, POL_RAND} repl_pol_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WRITE} alloc_st_e;
endpackage

// File: rtl/set_range_table.sv
module set_range_table #(
  parameter int ROWS  = 64,
  parameter int NSETS = 32,
  parameter int ROW_W = 6,
  parameter int SZ_W  = 7,
  parameter int SET_W = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [SET_W-1:0]                  set_i,
  input  logic [ROW_W-1:0]                  base_i,
  input  logic [SZ_W-1:0]                   size_i,
  output logic                              err_o,
  output logic                              load_o,
  output logic [NSETS-1:0][ROW_W-1:0]       base_o,
  output logic [NSETS-1:0][SZ_W-1:0]        size_o
);
  logic [NSETS-1:0][ROW_W-1:0] base_q, base_d;
  logic [NSETS-1:0][SZ_W-1:0]  size_q, size_d;
  logic err_q, err_d;
  logic [SZ_W:0] new_end;
  logic out_of_range, overlap;

  always_comb begin
    new_end      = {1'b0, {(SZ_W-ROW_W){1'b0}}, base_i} + {1'b0, size_i};
    out_of_range = new_end > (SZ_W+1)'(ROWS);
    overlap      = 1'b0;
    for (int k = 0; k < NSETS; k++) begin
      if (SET_W'(k) != set_i && size_q[k] != '0 && size_i != '0 &&
          {1'b0, {(SZ_W-ROW_W){1'b0}}, base_i} <
            {1'b0, {(SZ_W-ROW_W){1'b0}}, base_q[k]} + {1'b0, size_q[k]} &&
          {1'b0, {(SZ_W-ROW_W){1'b0}}, base_q[k]} < new_end)
        overlap = 1'b1;
    end
    load_o = we_i && !out_of_range && !overlap;
    err_d  = we_i && (out_of_range || overlap);
    base_d = base_q;
    size_d = size_q;
    if (load_o) begin
      base_d[set_i] = base_i;
      size_d[set_i] = size_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      err_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      size_q <= size_d;
      err_q  <= err_d;
    end
  end

  assign base_o = base_q;
  assign size_o = size_q;
  assign err_o  = err_q;

  AST_BAD_CFG_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(size_q)) else $error("rejected range was stored"); // R2
  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(we_i)) else $error("config error without a write"); // R3
endmodule

// File: rtl/row_age_track.sv
module row_age_track #(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6,
  parameter int SZ_W  = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush_i,
  input  logic                           touch_i,
  input  logic [ROW_W-1:0]               row_i,
  input  logic [SZ_W-1:0]                lo_i,
  input  logic [SZ_W-1:0]                hi_i,
  output logic [ROWS-1:0]                occ_o,
  output logic [ROWS-1:0][ROW_W-1:0]     age_o
);
  logic [ROWS-1:0]            occ_q, occ_d;
  logic [ROWS-1:0][ROW_W-1:0] age_q, age_d;

  always_comb begin
    occ_d = occ_q;
    age_d = age_q;
    if (flush_i) begin
      occ_d = '0;
    end else if (touch_i) begin
      for (int j = 0; j < ROWS; j++) begin
        if (SZ_W'(j) >= lo_i && SZ_W'(j) < hi_i && occ_q[j] &&
            ROW_W'(j) != row_i &&
            (!occ_q[row_i] || age_q[j] < age_q[row_i]))
          age_d[j] = age_q[j] + 1'b1;
      end
      occ_d[row_i] = 1'b1;
      age_d[row_i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      age_q <= '0;
    end else begin
      occ_q <= occ_d;
      age_q <= age_d;
    end
  end

  assign occ_o = occ_q;
  assign age_o = age_q;

  AST_TOUCHED_IS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_i && !flush_i) |=> (occ_q[$past(row_i)] && age_q[$past(row_i)] == '0))
    else $error("touched row not newest"); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (occ_q == '0)) else $error("flush left rows occupied"); // R9
endmodule

// File: rtl/alloc_lfsr.sv
module alloc_lfsr #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [LW-1:0] val_o
);
  logic [LW-1:0] st_q, st_d;

  always_comb begin
    st_d = {1'b0, st_q[LW-1:1]};
    if (st_q[0]) st_d = st_d ^ LW'(16'hB400);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LW'(1);
    else        st_q <= st_d;
  end

  assign val_o = st_q;
endmodule

// File: rtl/prefix_row_alloc.sv
module prefix_row_alloc
  import prefix_alloc_pkg::*;
#(
  parameter int        ROWS   = 64,
  parameter int        NSETS  = 32,
  parameter int        KEY_W  = 32,
  parameter int        PORT_W = 4,
  parameter repl_pol_e POLICY = POL_LRU,
  localparam int ROW_W = $clog2(ROWS),
  localparam int SZ_W  = $clog2(ROWS + 1),
  localparam int SET_W = $clog2(NSETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [ROW_W-1:0]  cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  output logic              cfg_err,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [SET_W-1:0]  ins_set,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [PORT_W-1:0] ins_port,
  output logic              ins_err,
  input  logic              hit_valid,
  input  logic [SET_W-1:0]  hit_set,
  input  logic [ROW_W-1:0]  hit_row,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [KEY_W-1:0]  wr_key,
  output logic [KEY_W-1:0]  wr_care,
  output logic [PORT_W-1:0] wr_port
);
  localparam int LW = 16;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  alloc_st_e st_q, st_d;
  logic [SET_W-1:0]  set_q, set_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [ROW_W-1:0]  base_q, base_d;
  logic [SZ_W-1:0]   size_q, size_d, idx_q, idx_d;
  logic              free_q, free_d, cand_ok_q, cand_ok_d, err_q, err_d;
  logic [ROW_W-1:0]  free_row_q, free_row_d, cand_q, cand_d, rnd_q, rnd_d;
  logic [ROW_W-1:0]  cand_age_q, cand_age_d, cur, victim;

  logic [NSETS-1:0][ROW_W-1:0] set_base;
  logic [NSETS-1:0][SZ_W-1:0]  set_size;
  logic [ROWS-1:0]             occ;
  logic [ROWS-1:0][ROW_W-1:0]  age;
  logic [LW-1:0]               rnd;
  logic cfg_go, cfg_load, accept, touch, hit_in_set;
  logic [ROW_W-1:0] touch_row;
  logic [SZ_W-1:0]  touch_lo, touch_hi, hit_lo, hit_hi;

  assign cfg_go    = cfg_we && st_q == ST_IDLE;
  assign ins_ready = st_q == ST_IDLE && !cfg_we;
  assign accept    = ins_valid && ins_ready;

  set_range_table #(.ROWS(ROWS), .NSETS(NSETS), .ROW_W(ROW_W), .SZ_W(SZ_W),
                    .SET_W(SET_W)) u_ranges (
    .clk(clk), .rst_n(rst_s), .we_i(cfg_go), .set_i(cfg_set), .base_i(cfg_base),
    .size_i(cfg_size), .err_o(cfg_err), .load_o(cfg_load),
    .base_o(set_base), .size_o(set_size));

  alloc_lfsr #(.LW(LW)) u_lfsr (.clk(clk), .rst_n(rst_s), .val_o(rnd));

  assign cur        = base_q + idx_q[ROW_W-1:0];
  assign hit_lo     = {{(SZ_W-ROW_W){1'b0}}, set_base[hit_set]};
  assign hit_hi     = hit_lo + set_size[hit_set];
  assign hit_in_set = {{(SZ_W-ROW_W){1'b0}}, hit_row} >= hit_lo &&
                      {{(SZ_W-ROW_W){1'b0}}, hit_row} < hit_hi;

  generate
    if (POLICY == POL_FIFO) begin : g_fifo_touch
      assign touch     = st_q == ST_WRITE;
      assign touch_row = victim;
      assign touch_lo  = {{(SZ_W-ROW_W){1'b0}}, base_q};
      assign touch_hi  = {{(SZ_W-ROW_W){1'b0}}, base_q} + size_q;
    end else begin : g_hit_touch
      assign touch     = st_q == ST_WRITE || (hit_valid && hit_in_set);
      assign touch_row = st_q == ST_WRITE ? victim : hit_row;
      assign touch_lo  = st_q == ST_WRITE ? {{(SZ_W-ROW_W){1'b0}}, base_q} : hit_lo;
      assign touch_hi  = st_q == ST_WRITE ? {{(SZ_W-ROW_W){1'b0}}, base_q} + size_q
                                          : hit_hi;
    end
  endgenerate

  row_age_track #(.ROWS(ROWS), .ROW_W(ROW_W), .SZ_W(SZ_W)) u_age (
    .clk(clk), .rst_n(rst_s), .flush_i(cfg_load), .touch_i(touch),
    .row_i(touch_row), .lo_i(touch_lo), .hi_i(touch_hi), .occ_o(occ), .age_o(age));

  generate
    if (POLICY == POL_RAND) begin : g_rand_victim
      assign victim = free_q ? free_row_q : rnd_q;
    end else begin : g_age_victim
      assign victim = free_q ? free_row_q : cand_q;
    end
  endgenerate

  always_comb begin
    st_d = st_q;  set_d = set_q;  key_d = key_q;  port_d = port_q;
    base_d = base_q;  size_d = size_q;  idx_d = idx_q;
    free_d = free_q;  free_row_d = free_row_q;
    cand_ok_d = cand_ok_q;  cand_d = cand_q;  cand_age_d = cand_age_q;
    rnd_d = rnd_q;  err_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        set_d  = ins_set;  key_d = ins_key;  port_d = ins_port;
        base_d = set_base[ins_set];
        size_d = set_size[ins_set];
        idx_d  = '0;  free_d = 1'b0;  cand_ok_d = 1'b0;
        rnd_d  = set_base[ins_set] + ROW_W'(rnd % LW'(set_size[ins_set] == '0
                                                ? SZ_W'(1) : set_size[ins_set]));
        if (set_size[ins_set] == '0) err_d = 1'b1;
        else                          st_d  = ST_SCAN;
      end
      ST_SCAN: begin
        if (!occ[cur] && !free_q) begin
          free_d = 1'b1;  free_row_d = cur;
        end else if (occ[cur] && (!cand_ok_q || age[cur] > cand_age_q)) begin
          cand_ok_d = 1'b1;  cand_d = cur;  cand_age_d = age[cur];
        end
        if (idx_q == size_q - 1'b1) st_d = ST_WRITE;
        else                        idx_d = idx_q + 1'b1;
      end
      ST_WRITE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE;  set_q <= '0;  key_q <= '0;  port_q <= '0;
      base_q <= '0;  size_q <= '0;  idx_q <= '0;  free_q <= 1'b0;
      free_row_q <= '0;  cand_ok_q <= 1'b0;  cand_q <= '0;  cand_age_q <= '0;
      rnd_q <= '0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  set_q <= set_d;  key_q <= key_d;  port_q <= port_d;
      base_q <= base_d;  size_q <= size_d;  idx_q <= idx_d;  free_q <= free_d;
      free_row_q <= free_row_d;  cand_ok_q <= cand_ok_d;  cand_q <= cand_d;
      cand_age_q <= cand_age_d;  rnd_q <= rnd_d;  err_q <= err_d;
    end
  end

  assign ins_err = err_q;
  assign wr_en   = st_q == ST_WRITE;
  assign wr_row  = victim;
  assign wr_care = {KEY_W{1'b1}} << set_q;
  assign wr_key  = key_q & wr_care;
  assign wr_port = port_q;

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> !wr_en) else $error("write strobe longer than one cycle"); // R7
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |-> (wr_row >= set_base[set_q] &&
               {{(SZ_W-ROW_W){1'b0}}, wr_row} <
               {{(SZ_W-ROW_W){1'b0}}, set_base[set_q]} + set_size[set_q]))
    else $error("write outside the set range"); // R8
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_s)
    ins_err |-> (!wr_en && $past(ins_valid && ins_ready)))
    else $error("insert error without an accepted insert"); // R4
  AST_NOT_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (accept && set_base[ins_set] == set_base[ins_set] && set_size[ins_set] != '0)
    |=> !ins_ready) else $error("ready during scan"); // R7
endmodule

// File: tb/prefix_row_alloc_test.sv
module prefix_row_alloc_test;
  localparam int ROWS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_set = '0;
  logic [5:0]  cfg_base = '0;
  logic [6:0]  cfg_size = '0;
  logic        cfg_err;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [4:0]  ins_set = '0;
  logic [31:0] ins_key = '0;
  logic [3:0]  ins_port = '0;
  logic        ins_err;
  logic        hit_valid = 1'b0;
  logic [4:0]  hit_set = '0;
  logic [5:0]  hit_row = '0;
  logic        wr_en;
  logic [5:0]  wr_row;
  logic [31:0] wr_key, wr_care;
  logic [3:0]  wr_port;

  prefix_row_alloc uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set(cfg_set),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_err(cfg_err),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_set(ins_set),
    .ins_key(ins_key), .ins_port(ins_port), .ins_err(ins_err),
    .hit_valid(hit_valid), .hit_set(hit_set), .hit_row(hit_row),
    .wr_en(wr_en), .wr_row(wr_row), .wr_key(wr_key), .wr_care(wr_care),
    .wr_port(wr_port));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int m_base [32];
  int m_size [32];
  bit m_occ  [ROWS];
  int m_age  [ROWS];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pick_victim(input int s);
    int best = -1;
    for (int r = m_base[s]; r < m_base[s] + m_size[s]; r++)
      if (!m_occ[r]) return r;
    for (int r = m_base[s]; r < m_base[s] + m_size[s]; r++)
      if (best < 0 || m_age[r] > m_age[best]) best = r;
    return best;
  endfunction

  function automatic void model_touch(input int s, input int row);
    for (int r = m_base[s]; r < m_base[s] + m_size[s]; r++)
      if (r != row && m_occ[r] && (!m_occ[row] || m_age[r] < m_age[row]))
        m_age[r]++;
    m_occ[row] = 1'b1;
    m_age[row] = 0;
  endfunction

  task automatic do_cfg(input int s, input int b, input int sz, input bit exp_err, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = 5'(s); cfg_base = 6'(b); cfg_size = 7'(sz);
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_err == exp_err, req, cfg_err, exp_err);
    if (!exp_err) begin
      m_base[s] = b; m_size[s] = sz;
      for (int r = 0; r < ROWS; r++) m_occ[r] = 1'b0;
    end
  endtask

  task automatic do_hit(input int s, input int row);
    @(negedge clk);
    hit_valid = 1'b1; hit_set = 5'(s); hit_row = 6'(row);
    @(negedge clk);
    hit_valid = 1'b0;
    model_touch(s, row);
  endtask

  task automatic do_ins(input int s, input logic [31:0] key, input logic [3:0] port, input string req);
    int n = 0;
    int exp_row;
    logic [31:0] care;
    @(negedge clk);
    ins_valid = 1'b1; ins_set = 5'(s); ins_key = key; ins_port = port;
    @(negedge clk);
    ins_valid = 1'b0;
    if (m_size[s] == 0) begin
      check(ins_err == 1'b1 && wr_en == 1'b0, "R4 zero-size insert error", ins_err, 1);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(wr_en == 1'b0 && ins_err == 1'b0, "R4 no write after error", wr_en, 0);
      end
      return;
    end
    n = 1;
    while (!wr_en && n < m_size[s] + 6) begin
      check(ins_ready == 1'b0, "R7 ready low while busy", ins_ready, 0);
      @(negedge clk);
      n++;
    end
    check(n == m_size[s] + 1, "R7 write latency", n, m_size[s] + 1);
    exp_row = pick_victim(s);
    check(wr_row == 6'(exp_row), req, wr_row, exp_row);
    care = 32'hFFFF_FFFF << s;
    check(wr_care == care && wr_key == (key & care) && wr_port == port,
          "R8 write data", {wr_key, wr_port}, {key & care, port});
    model_touch(s, exp_row);
    @(negedge clk);
    check(wr_en == 1'b0, "R7 single write cycle", wr_en, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int sets [5] = '{0, 8, 9, 12, 16};
    process::self().srandom(32'd1357);
    for (int s = 0; s < 32; s++) begin m_base[s] = 0; m_size[s] = 0; end
    for (int r = 0; r < ROWS; r++) begin m_occ[r] = 0; m_age[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ins_ready == 1 && wr_en == 0 && ins_err == 0 && cfg_err == 0,
          "R1 reset state", {ins_ready, wr_en, ins_err, cfg_err}, 4'b1000);
    do_ins(3, 32'h1234_5678, 4'h1, "R1 empty set after reset");

    do_cfg(0, 0, 1, 0, "R3 legal config set 0");
    do_cfg(8, 1, 6, 0, "R3 legal config set 8");
    do_cfg(9, 7, 3, 0, "R3 legal config set 9");
    do_cfg(12, 20, 5, 0, "R3 legal config set 12");
    do_cfg(16, 10, 2, 0, "R3 legal config set 16");
    do_cfg(20, 60, 8, 1, "R2 range past last row");
    do_ins(20, 32'hAAAA_0000, 4'h2, "R2 rejected range stays empty");
    do_cfg(21, 3, 2, 1, "R3 overlap with set 8");
    do_ins(21, 32'hBBBB_0000, 4'h3, "R3 rejected overlap stays empty");
    do_ins(31, 32'hCCCC_0000, 4'h4, "R4 zero-size set");

    for (int k = 0; k < 6; k++)
      do_ins(8, $urandom, 4'($urandom), "R5 lowest free row");
    do_hit(8, 1);
    do_ins(8, 32'hC0A8_0100, 4'h5, "R6 evict oldest after hit");
    do_hit(8, 3);
    do_hit(8, 4);
    do_ins(8, 32'h0A00_0000, 4'h6, "R6 evict oldest after two hits");
    do_ins(0, 32'hDEAD_BEEF, 4'h7, "R5 single-row set");
    do_ins(0, 32'hFEED_F00D, 4'h8, "R6 single-row set eviction");

    for (int it = 0; it < 400; it++) begin
      int s = sets[$urandom_range(0, 4)];
      if ($urandom_range(0, 2) != 0) begin
        do_ins(s, $urandom, 4'($urandom), "R6 random insert victim");
      end else begin
        int row = m_base[s] + $urandom_range(0, m_size[s] - 1);
        if (m_occ[row]) do_hit(s, row);
      end
    end

    do_cfg(16, 10, 2, 0, "R9 reload set 16");
    do_ins(8, 32'h0102_0304, 4'h9, "R9 flushed set restarts at base");
    check(m_base[8] == 1, "R9 base row of set 8", m_base[8], 1);
    do_ins(12, 32'h0506_0708, 4'hA, "R9 flushed set 12 restarts at base");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule